// File: doc/BRIEF.md
# Ramp Controller Configuration Commit Registers

This block is the device-facing register slice of a CPU clock ramp controller. Software reaches it over a plain synchronous register bus with a byte address, write enable, write data, read enable and read data. Two registers are mapped. The command register carries a root-enable control and a hardware busy flag. The commit register lets software hand a configuration entry, named by a small sequence ID, to the controller and then wait for a one-hot acknowledge.

A commit is a two-step exchange. Software first stores the entry ID and then sets the update-enable bit. After a programmable delay the block raises the acknowledge bit whose position is the ID plus sixteen. The register keeps its contents after the commit. Software writes an all-zero word to release it, and the whole acknowledge field then drops after a second programmable delay. Setting root enable raises the busy flag, which falls again after a third programmable delay.

The register bus is control traffic, so it has no back-pressure. A write takes effect at the clock edge where it is sampled. Read data appears one cycle after the read request and is zero in every other cycle. Each of the three delays is a parameter counted in clock cycles, and the smallest allowed value is 1.

Top module: `ramp_cfg_regs`

## Requirements
- R1: After reset, the command register (byte offset 0x00) and the commit register (byte offset 0x60) both read as zero.
- R2: A write to the command register with bit 1 (root enable) set makes bit 1 and bit 0 (busy) read as 1. Bit 0 still reads as 1 on a read issued ROOT_DLY+1 cycles after the write cycle and reads as 0 on a read issued ROOT_DLY+2 cycles after it. Bit 1 stays set.
- R3: Bit 0 of the command register is not writable: a write of 0x1 leaves the register reading zero.
- R4: The commit register keeps the entry ID in bits 3:0 and update enable in bit 8, and both read back as written. Writes to bits 31:16 are ignored.
- R5: When update enable becomes set while the acknowledge field is zero, bit 16+ID alone is set. A read issued CMT_DLY+1 cycles after the write does not show it, and a read issued CMT_DLY+2 cycles after it does.
- R6: The acknowledge bit, the ID and update enable remain set for as long as software does not write zero.
- R7: A write of the all-zero word to the commit register clears the ID and update enable at once. The acknowledge field reads nonzero on a read issued CLR_DLY+1 cycles after the write and reads zero on one issued CLR_DLY+2 cycles after it.
- R8: Writing update enable, even with a new ID, while the acknowledge field is nonzero starts no commit: the acknowledge field keeps its old value.
- R9: Reads of any other byte offset return zero, and writes to them change neither register.
- R10: Every ID from 0 to 15 is committed correctly; IDs 2, 3, 6, 14 and 15 are exercised.
- R11: Read data is registered. It holds the addressed value in the cycle after a read request and is zero in the cycle after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write request, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read request |
| bus_rdata | output | 32 | Read data, valid one cycle after bus_re |

## Verification
The hardest case to reach from the bus is a commit request that arrives while an earlier acknowledge is still up. The bench reaches it by completing a commit and then, without releasing the register, writing update enable again with a different ID; it then reads back and expects the old one-hot bit to stay unchanged. Every delay is checked by reading the register in each cycle after the triggering write. The scoreboard holds the old value for every read before the edge where the change is due and the new value for every read from that edge on, so a delay that is one cycle long or short is reported.

// File: rtl/rc_pkg.sv
package rc_pkg;
  localparam int unsigned DATA_W      = 32;
  // command register fields
  localparam int unsigned CMD_BUSY    = 0;
  localparam int unsigned CMD_ROOT    = 1;
  // commit register placement and fields
  localparam int unsigned UPD_OFFSET  = 'h60;
  localparam int unsigned UPD_EN      = 8;
  localparam int unsigned UPD_ACK_LSB = 16;
  localparam int unsigned UPD_ACK_MAX = DATA_W - UPD_ACK_LSB;
endpackage

// File: rtl/rc_delay_timer.sv
// Countdown: done pulses DLY cycles after the edge that sampled start.
module rc_delay_timer #(
  parameter int unsigned DLY = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cancel,
  output logic busy,
  output logic done
);
  localparam int unsigned DLY_I = (DLY < 1) ? 1 : DLY;
  localparam int unsigned CW    = (DLY_I > 1) ? $clog2(DLY_I) : 1;

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == '0) && !cancel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel) begin
      busy_q <= 1'b0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(DLY_I - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/rc_cmd_reg.sv
// Command register: root enable plus the root-update busy flag.
module rc_cmd_reg #(
  parameter int unsigned ROOT_DLY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic wr_root,
  output logic root_en,
  output logic busy
);
  logic root_q, busy_q, kick_q;
  logic tmr_busy, tmr_done;

  assign root_en = root_q;
  assign busy    = busy_q;

  rc_delay_timer #(.DLY(ROOT_DLY)) u_root_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (kick_q),
    .cancel (1'b0),
    .busy   (tmr_busy),
    .done   (tmr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      root_q <= 1'b0;
      busy_q <= 1'b0;
      kick_q <= 1'b0;
    end else begin
      kick_q <= wr && wr_root;
      if (wr) begin
        root_q <= wr_root;
        if (wr_root) busy_q <= 1'b1;
        else if (tmr_done) busy_q <= 1'b0;
      end else if (tmr_done && !kick_q) begin
        busy_q <= 1'b0;
      end
    end
  end

  logic unused_tmr;
  assign unused_tmr = tmr_busy;
endmodule

// File: rtl/rc_upd_reg.sv
// Commit register: entry ID, update enable, one-hot acknowledge.
module rc_upd_reg #(
  parameter int unsigned ID_W    = 4,
  parameter int unsigned CMT_DLY = 3,
  parameter int unsigned CLR_DLY = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [rc_pkg::DATA_W-1:0] wdata,
  output logic [ID_W-1:0]           id,
  output logic                      en,
  output logic [(1<<ID_W)-1:0]      ack,
  output logic                      cmt_busy,
  output logic                      clr_busy,
  output logic                      clr_req
);
  localparam int unsigned ACK_W = 1 << ID_W;

  logic [ID_W-1:0]  id_q, id_lat_q;
  logic             en_q, clr_req_q;
  logic [ACK_W-1:0] ack_q, ack_onehot;
  logic             zero_wr, cmt_go, cmt_done, clr_done;

  assign zero_wr  = wr && (wdata == '0);
  assign cmt_go   = en_q && (ack_q == '0) && !cmt_busy && !clr_busy && !clr_req_q;
  assign id       = id_q;
  assign en       = en_q;
  assign ack      = ack_q;
  assign clr_req  = clr_req_q;

  // one-hot decode of the latched entry ID
  for (genvar g = 0; g < ACK_W; g++) begin : g_dec
    assign ack_onehot[g] = (id_lat_q == ID_W'(g));
  end

  rc_delay_timer #(.DLY(CMT_DLY)) u_cmt_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (cmt_go),
    .cancel (zero_wr),
    .busy   (cmt_busy),
    .done   (cmt_done)
  );

  rc_delay_timer #(.DLY(CLR_DLY)) u_clr_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (clr_req_q),
    .cancel (1'b0),
    .busy   (clr_busy),
    .done   (clr_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q      <= '0;
      en_q      <= 1'b0;
      id_lat_q  <= '0;
      clr_req_q <= 1'b0;
      ack_q     <= '0;
    end else begin
      clr_req_q <= zero_wr;
      if (wr) begin
        id_q <= wdata[ID_W-1:0];
        en_q <= wdata[rc_pkg::UPD_EN];
      end
      if (cmt_go) id_lat_q <= id_q;
      if (clr_done)      ack_q <= '0;
      else if (cmt_done) ack_q <= ack_onehot;
    end
  end
endmodule

// File: rtl/ramp_cfg_regs.sv
// Top: address decode, registered read mux, two register slices.
module ramp_cfg_regs #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned ID_W     = 4,   // at most 4: acknowledge lives in bits 31:16
  parameter int unsigned CMT_DLY  = 3,
  parameter int unsigned CLR_DLY  = 2,
  parameter int unsigned ROOT_DLY = 5,
  parameter int unsigned CMD_BASE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata
);
  import rc_pkg::*;
  localparam int unsigned ACK_W    = 1 << ID_W;
  localparam int unsigned UPD_ADDR = CMD_BASE + UPD_OFFSET;

  logic             hit_cmd, hit_upd;
  logic             root_en, busy_flag;
  logic [ID_W-1:0]  upd_id;
  logic             upd_en;
  logic [ACK_W-1:0] ack_vec;
  logic             cmt_busy, clr_busy, clr_req;
  logic [31:0]      cmd_val, upd_val, rd_mux, rdata_q;

  assign hit_cmd = (bus_addr == ADDR_W'(CMD_BASE));
  assign hit_upd = (bus_addr == ADDR_W'(UPD_ADDR));

  rc_cmd_reg #(.ROOT_DLY(ROOT_DLY)) u_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_we && hit_cmd),
    .wr_root (bus_wdata[CMD_ROOT]),
    .root_en (root_en),
    .busy    (busy_flag)
  );

  rc_upd_reg #(.ID_W(ID_W), .CMT_DLY(CMT_DLY), .CLR_DLY(CLR_DLY)) u_upd (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (bus_we && hit_upd),
    .wdata    (bus_wdata),
    .id       (upd_id),
    .en       (upd_en),
    .ack      (ack_vec),
    .cmt_busy (cmt_busy),
    .clr_busy (clr_busy),
    .clr_req  (clr_req)
  );

  always_comb begin
    cmd_val           = '0;
    cmd_val[CMD_BUSY] = busy_flag;
    cmd_val[CMD_ROOT] = root_en;
    upd_val                     = '0;
    upd_val[ID_W-1:0]           = upd_id;
    upd_val[UPD_EN]             = upd_en;
    upd_val[UPD_ACK_LSB +: ACK_W] = ack_vec;
    if (hit_cmd)      rd_mux = cmd_val;
    else if (hit_upd) rd_mux = upd_val;
    else              rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= bus_re ? rd_mux : '0;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/ramp_cfg_regs_chk.sv
module ramp_cfg_regs_chk #(
  parameter int unsigned ACK_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_we,
  input logic             bus_re,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic             hit_cmd,
  input logic             hit_upd,
  input logic             busy_flag,
  input logic [ACK_W-1:0] ack_vec,
  input logic             cmt_busy,
  input logic             clr_busy,
  input logic             clr_req
);
  assert_ack_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_vec));

  assert_no_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0 && !clr_busy && !clr_req) |=> $stable(ack_vec));

  assert_ignore_when_acked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_vec != '0 && !cmt_busy) |=> !cmt_busy);

  assert_busy_on_root_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_cmd && bus_wdata[1]) |=> busy_flag);

  assert_zero_write_aborts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_upd && bus_wdata == '0) |=> !cmt_busy);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !hit_cmd && !hit_upd) |=> (bus_rdata == '0));

  assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> (bus_rdata == '0));
endmodule

bind ramp_cfg_regs ramp_cfg_regs_chk #(.ACK_W(ACK_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_re    (bus_re),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .hit_cmd   (hit_cmd),
  .hit_upd   (hit_upd),
  .busy_flag (busy_flag),
  .ack_vec   (ack_vec),
  .cmt_busy  (cmt_busy),
  .clr_busy  (clr_busy),
  .clr_req   (clr_req)
);

// File: tb/sim_ramp_cfg_regs.sv
module sim_ramp_cfg_regs;
  localparam int CLK_PERIOD = 10;
  localparam int CMT  = 3;
  localparam int CLR  = 2;
  localparam int ROOT = 5;
  localparam logic [7:0] A_CMD = 8'h00;
  localparam logic [7:0] A_UPD = 8'h60;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_re = 1'b0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;
  logic re_q = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_cfg_regs #(.ADDR_W(8), .ID_W(4), .CMT_DLY(CMT), .CLR_DLY(CLR),
                  .ROOT_DLY(ROOT), .CMD_BASE(0)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata));

  // monitor: pop the scoreboard one cycle after each read request
  always @(posedge clk) re_q <= bus_re;
  always @(negedge clk) begin
    if (re_q) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic bus_op(input logic we, input logic re, input logic [7:0] a,
                        input logic [31:0] d, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_we = we; bus_re = re; bus_addr = a; bus_wdata = d;
    if (re) begin
      exp_q.push_back(e);
      tag_q.push_back(t);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_op(1'b1, 1'b0, a, d, '0, "");
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    bus_op(1'b0, 1'b1, a, '0, e, t);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) bus_op(1'b0, 1'b0, '0, '0, '0, "");
  endtask

  // reads every cycle after a write; the change is due on read dly+2
  task automatic watch(input logic [7:0] a, input logic [31:0] old_v,
                       input logic [31:0] new_v, input int dly, input string t);
    for (int k = 1; k <= dly + 4; k++)
      rd(a, (k < dly + 2) ? old_v : new_v, t);
  endtask

  task automatic commit_release(input int id, input string t);
    logic [31:0] low;
    logic [31:0] ackb;
    low  = 32'h100 | 32'(id);
    ackb = 32'h1 << (16 + id);
    wr(A_UPD, low);
    watch(A_UPD, low, ackb | low, CMT, t);
    wr(A_UPD, 32'h0);
    watch(A_UPD, ackb, 32'h0, CLR, t);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all): got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset values
    rd(A_CMD, 32'h0, "R1 command after reset");
    rd(A_UPD, 32'h0, "R1 commit after reset");

    // R3 busy flag not writable
    wr(A_CMD, 32'h1);
    rd(A_CMD, 32'h0, "R3 busy bit write ignored");

    // R2 root enable sets busy, busy clears after ROOT delay
    wr(A_CMD, 32'h2);
    watch(A_CMD, 32'h3, 32'h2, ROOT, "R2 root busy window");

    // R4 fields read back, acknowledge bits not writable
    wr(A_UPD, 32'h0000_0002);
    rd(A_UPD, 32'h0000_0002, "R4 id readback");
    wr(A_UPD, 32'hABCD_0005);
    rd(A_UPD, 32'h0000_0005, "R4 ack field write ignored");
    wr(A_UPD, 32'h0);
    idle(CLR + 2);

    // R5 commit of id 2
    wr(A_UPD, 32'h0000_0102);
    watch(A_UPD, 32'h0000_0102, 32'h0004_0102, CMT, "R5 commit id 2");

    // R6 no self clear
    idle(12);
    rd(A_UPD, 32'h0004_0102, "R6 register holds after commit");

    // R8 new request while acknowledged is ignored
    wr(A_UPD, 32'h0000_010E);
    for (int k = 0; k < CMT + 4; k++)
      rd(A_UPD, 32'h0004_010E, "R8 ack unchanged while set");

    // R7 zero write clears fields now, ack after CLR delay
    wr(A_UPD, 32'h0);
    watch(A_UPD, 32'h0004_0000, 32'h0, CLR, "R7 release window");

    // R10 range of entry IDs
    commit_release(3,  "R10 id 3");
    commit_release(6,  "R10 id 6");
    commit_release(14, "R10 id 14");
    commit_release(15, "R10 id 15");
    commit_release(2,  "R10 id 2");

    // R9 unmapped offsets
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);
    wr(8'h61, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0, "R9 unmapped 0x04 reads zero");
    rd(8'h61, 32'h0, "R9 unmapped 0x61 reads zero");
    rd(A_CMD, 32'h2, "R9 command unchanged");
    rd(A_UPD, 32'h0, "R9 commit unchanged");

    // R11 read data zero without a read request
    idle(2);
    checks++;
    if (bus_rdata !== 32'h0) begin
      errors++;
      $display("FAIL R11 idle read data: got %h expected %h", bus_rdata, 32'h0);
    end

    idle(3);
    wait (exp_q.size() == 0);
    idle(1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule